// File: doc/BRIEF.md
# Segmented Page Translation Register Unit

This block holds the page translation table for an 8-bit CPU with a 16-bit address space. The table has four segments of sixteen entries each. Every entry is a 6-bit physical page number. Software reaches the table through a fixed 16-byte I/O window, and a segment select register chooses which segment that window shows. The same unit also holds a control register, with mapping enable, window enable and a RAM-boot flag, and an 8-bit window offset register. The window offset is only stored and brought out; the window address arithmetic happens elsewhere.

The translation port has no register in its path. The CPU's top four address bits go in, and a 6-bit physical page comes out in the same cycle. When mapping is enabled, that page comes from the table entry of the current segment. When mapping is disabled, the page is a fixed 0x30 plus the four address bits. The I/O port is a plain register interface: a write strobe takes effect at the clock edge, and read data is a combinational function of the address. Neither port uses valid/ready, because each completes in one cycle and never stalls.

There are two resets. The power-on reset `por_n` loads the default table and clears every register. The ordinary reset `rst_n` clears only the three control flags.

Top module: `mmr_unit`

## Requirements
- R1: A write to an offset 0x80+k (k = 0..15) stores wdata[5:0] in entry segment*16+k. A read of 0x80+k returns {2'b00, entry}.
- R2: A write to offset 0x90 keeps wdata[1:0] as the segment select. The select then chooses which sixteen entries the window reaches. No other offset changes the segment.
- R3: After power-on reset, entry i holds 0x30+i for i < 16 and 0 for every other entry. The segment, the control flags and the window offset are all 0.
- R4: A write to offset 0x93 loads boot_ram from bit 0, win_en from bit 6 and map_en from bit 7. A read of 0x93 returns 0x3E with bit 7 = map_en, bit 6 = win_en and bit 0 = boot_ram.
- R5: A write to offset 0x92 loads all 8 bits into win_offset.
- R6: While rst_n is low, map_en, win_en and boot_ram are 0. rst_n leaves the table, the segment and win_offset unchanged.
- R7: While map_en is 1, phys_page equals the entry at segment*16 + cpu_page.
- R8: While map_en is 0, phys_page equals 0x30 + cpu_page.
- R9: A read of any offset other than 0x80..0x8F and 0x93 returns 0xFF. A write to any offset other than 0x80..0x8F, 0x90, 0x92 and 0x93 changes no state.
- R10: A table write and a translation of the same entry in the same cycle: phys_page shows the old value before the edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; initialises table and registers |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous; clears control flags only |
| io_addr | input | 8 | I/O register offset |
| io_wr | input | 1 | Write strobe, taken at the clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr (combinational) |
| cpu_page | input | 4 | CPU address bits [15:12] |
| phys_page | output | 6 | Translated physical page |
| map_en | output | 1 | Mapping enable flag |
| win_en | output | 1 | Window enable flag |
| boot_ram | output | 1 | RAM boot flag |
| win_offset | output | 8 | Window offset register |

## Verification
A table write through the I/O port and a lookup through the translation port can touch the same entry in the same cycle. The bench provokes this with mapping enabled, cpu_page set to the page being written, and a write to the matching window offset in the same cycle. It checks phys_page just after the inputs settle and expects the old entry. It checks phys_page again one cycle later and expects the new entry. A segment change while a translation is being presented is judged the same way: the new segment's entry must appear only after the edge that takes the 0x90 write.

// File: rtl/mmr_pkg.sv
package mmr_pkg;
  localparam int unsigned IO_W = 8;
  localparam logic [IO_W-1:0] OFS_WINDOW = 8'h80;
  localparam logic [IO_W-1:0] OFS_SEG    = 8'h90;
  localparam logic [IO_W-1:0] OFS_WOFF   = 8'h92;
  localparam logic [IO_W-1:0] OFS_CTRL   = 8'h93;
  localparam int unsigned BYPASS_BASE = 'h30;

  typedef struct packed {
    logic map_en;
    logic win_en;
    logic boot_ram;
  } mmr_flags_t;
endpackage

// File: rtl/mmr_table.sv
module mmr_table #(
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned ENT_W     = 6,
  parameter int unsigned INIT_N    = 16,
  parameter int unsigned INIT_BASE = 'h30
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] io_idx,
  output logic [ENT_W-1:0] io_data,
  input  logic [IDX_W-1:0] xl_idx,
  output logic [ENT_W-1:0] xl_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i < INIT_N) ? ENT_W'(INIT_BASE + i) : '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign io_data = mem[io_idx];
  assign xl_data = mem[xl_idx];

  // R1: a written entry holds the written value one cycle later
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/mmr_regs.sv
module mmr_regs
  import mmr_pkg::*;
#(
  parameter int unsigned SEG_W = 2
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IO_W-1:0] addr,
  input  logic [IO_W-1:0] wdata,
  output logic [SEG_W-1:0] seg,
  output logic [IO_W-1:0] woff,
  output mmr_flags_t      flags
);
  logic flag_rst_n;
  assign flag_rst_n = por_n & rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      seg  <= '0;
      woff <= '0;
    end else if (wr_en) begin
      if (addr == OFS_SEG)  seg  <= wdata[SEG_W-1:0];
      if (addr == OFS_WOFF) woff <= wdata;
    end
  end

  always_ff @(posedge clk or negedge flag_rst_n) begin
    if (!flag_rst_n) begin
      flags <= '0;
    end else if (wr_en && addr == OFS_CTRL) begin
      flags.map_en   <= wdata[7];
      flags.win_en   <= wdata[6];
      flags.boot_ram <= wdata[0];
    end
  end

  // R2: segment only moves on a segment-select write
  p_seg_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_en && addr == OFS_SEG) |=> $stable(seg));
  // R5: window offset takes the full written byte
  p_woff_load_r5: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr == OFS_WOFF) |=> (woff == $past(wdata)));
  // R6: ordinary reset holds the flags clear
  p_rst_flags_r6: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |-> (flags == '0));
endmodule

// File: rtl/mmr_unit.sv
module mmr_unit
  import mmr_pkg::*;
#(
  parameter int unsigned SEG_W  = 2,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned ENT_W  = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [7:0]        io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [PAGE_W-1:0] cpu_page,
  output logic [ENT_W-1:0]  phys_page,
  output logic              map_en,
  output logic              win_en,
  output logic              boot_ram,
  output logic [7:0]        win_offset
);
  localparam int unsigned IDX_W = SEG_W + PAGE_W;

  logic [SEG_W-1:0] seg;
  mmr_flags_t       flags;
  logic             win_hit;
  logic [ENT_W-1:0] io_ent, xl_ent;

  assign win_hit = (io_addr[7:PAGE_W] == OFS_WINDOW[7:PAGE_W]);

  mmr_regs #(.SEG_W(SEG_W)) u_regs (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .wr_en(io_wr), .addr(io_addr), .wdata(io_wdata),
    .seg(seg), .woff(win_offset), .flags(flags)
  );

  mmr_table #(
    .IDX_W(IDX_W), .ENT_W(ENT_W),
    .INIT_N(1 << PAGE_W), .INIT_BASE(BYPASS_BASE)
  ) u_table (
    .clk(clk), .por_n(por_n),
    .wr_en(io_wr && win_hit),
    .wr_idx({seg, io_addr[PAGE_W-1:0]}),
    .wr_data(io_wdata[ENT_W-1:0]),
    .io_idx({seg, io_addr[PAGE_W-1:0]}),
    .io_data(io_ent),
    .xl_idx({seg, cpu_page}),
    .xl_data(xl_ent)
  );

  always_comb begin
    if (win_hit)
      io_rdata = 8'(io_ent);
    else if (io_addr == OFS_CTRL)
      io_rdata = {flags.map_en, flags.win_en, 5'b11111, flags.boot_ram};
    else
      io_rdata = 8'hFF;
  end

  assign phys_page = flags.map_en ? xl_ent : ENT_W'(BYPASS_BASE + cpu_page);
  assign map_en    = flags.map_en;
  assign win_en    = flags.win_en;
  assign boot_ram  = flags.boot_ram;

  // R4: control readback carries the fixed ones and the live flags
  p_ctrl_read_r4: assert property (@(posedge clk) disable iff (!por_n)
    (io_addr == OFS_CTRL) |-> (io_rdata[5:1] == 5'b11111 &&
                               io_rdata[7] == map_en && io_rdata[0] == boot_ram));
  // R9: offsets outside the window and control read as all ones
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!win_hit && io_addr != OFS_CTRL) |-> (io_rdata == 8'hFF));
endmodule

// File: tb/mmr_unit_test.sv
module mmr_unit_test;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b1;
  logic [7:0] io_addr = '0, io_wdata = '0;
  logic       io_wr = 1'b0;
  logic [3:0] cpu_page = '0;
  logic [7:0] io_rdata, win_offset;
  logic [5:0] phys_page;
  logic       map_en, win_en, boot_ram;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [5:0] model [64];
  int seg_m = 0;

  always #5 clk = ~clk;

  mmr_unit uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_page(cpu_page),
    .phys_page(phys_page), .map_en(map_en), .win_en(win_en),
    .boot_ram(boot_ram), .win_offset(win_offset)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
    io_addr = a;
    #1;
    chk(req, io_rdata, exp);
  endtask

  task automatic sweep_window(input string req);
    for (int s = 0; s < 4; s++) begin
      wr(8'h90, 8'(s));
      for (int k = 0; k < 16; k++) rd_chk(req, 8'(8'h80 + k), model[s*16+k]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = (i < 16) ? 6'(8'h30 + i) : 6'h0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R3 power-on state
    chk("R3 map_en", map_en, 0); chk("R3 win_en", win_en, 0);
    chk("R3 boot_ram", boot_ram, 0); chk("R3 win_offset", win_offset, 0);
    rd_chk("R3 ctrl", 8'h93, 8'h3E);
    rd_chk("R3 seg0 entry", 8'h85, 8'h35);
    sweep_window("R3 table");

    // R8 bypass translation with mapping off
    for (int p = 0; p < 16; p++) begin
      cpu_page = 4'(p); #1; chk("R8 bypass", phys_page, 8'h30 + p);
    end

    // R1 write every entry with upper bits set, expect masking
    for (int s = 0; s < 4; s++) begin
      wr(8'h90, 8'(s));
      for (int k = 0; k < 16; k++) begin
        int v;
        v = ((s*16 + k) * 37 + 200) & 8'hFF;
        wr(8'(8'h80 + k), 8'(v));
        model[s*16+k] = 6'(v);
      end
    end
    sweep_window("R1 readback");

    // R2 only low two bits of segment kept
    wr(8'h90, 8'hFD); seg_m = 1;
    rd_chk("R2 seg masked", 8'h83, model[16+3]);

    // R4 control register
    wr(8'h93, 8'hC1);
    chk("R4 map_en", map_en, 1); chk("R4 win_en", win_en, 1); chk("R4 boot", boot_ram, 1);
    rd_chk("R4 ctrl all", 8'h93, 8'hFF);
    wr(8'h93, 8'h41); rd_chk("R4 ctrl win+boot", 8'h93, 8'h7F);
    wr(8'h93, 8'h3E); rd_chk("R4 ctrl none", 8'h93, 8'h3E);
    wr(8'h93, 8'h80); rd_chk("R4 ctrl map", 8'h93, 8'hBE);

    // R7 translation sweep over all segments
    for (int s = 0; s < 4; s++) begin
      wr(8'h90, 8'(s)); seg_m = s;
      for (int p = 0; p < 16; p++) begin
        cpu_page = 4'(p); #1; chk("R7 mapped", phys_page, model[s*16+p]);
      end
    end

    // R10 same-cycle write and translation of one entry
    @(negedge clk);
    cpu_page = 4'd9; io_addr = 8'h89; io_wdata = 8'h2A; io_wr = 1'b1;
    #1; chk("R10 before edge", phys_page, model[seg_m*16+9]);
    @(negedge clk); io_wr = 1'b0;
    model[seg_m*16+9] = 6'h2A;
    chk("R10 after edge", phys_page, 8'h2A);
    // R10 segment change under a held translation
    @(negedge clk);
    io_addr = 8'h90; io_wdata = 8'h00; io_wr = 1'b1;
    #1; chk("R10 seg before edge", phys_page, model[seg_m*16+9]);
    @(negedge clk); io_wr = 1'b0; seg_m = 0;
    chk("R10 seg after edge", phys_page, model[9]);

    // R5 window offset
    wr(8'h92, 8'hA7); chk("R5 offset", win_offset, 8'hA7);
    wr(8'h92, 8'h5C); chk("R5 offset2", win_offset, 8'h5C);

    // R9 unmapped reads
    for (int a = 0; a < 256; a++) begin
      if (!((a >= 8'h80 && a <= 8'h8F) || a == 8'h93))
        rd_chk("R9 unmapped read", 8'(a), 8'hFF);
    end
    // R9 unmapped writes leave state alone
    wr(8'h91, 8'h00); wr(8'h94, 8'h00); wr(8'h7F, 8'h00); wr(8'hA3, 8'h01); wr(8'h00, 8'h03);
    rd_chk("R9 ctrl kept", 8'h93, 8'hBE);
    chk("R9 offset kept", win_offset, 8'h5C);
    sweep_window("R9 table kept");
    wr(8'h90, 8'h02); seg_m = 2;
    wr(8'h93, 8'hC1);

    // R6 ordinary reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R6 map cleared", map_en, 0); chk("R6 win cleared", win_en, 0);
    chk("R6 boot cleared", boot_ram, 0);
    wr(8'h93, 8'hC1);
    chk("R6 held in reset", map_en, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R6 offset kept", win_offset, 8'h5C);
    rd_chk("R6 seg kept", 8'h84, model[2*16+4]);
    cpu_page = 4'd4; #1; chk("R6 bypass after reset", phys_page, 8'h34);
    sweep_window("R6 table kept");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule